// File: doc/BRIEF.md
# FIFO Drain Bridge

This block lets a processor empty an external FIFO with nothing more than ordinary bus reads. It sits between a plain memory-mapped read port and the read side of a FIFO whose output word updates a fixed number of cycles after a read request. When the processor reads the data address, the bridge pulses the FIFO's read request and hands back the word that the FIFO presents. When it reads the status address, it returns a flag that says whether the FIFO currently holds anything, and the FIFO is left alone.

The bus read latency is fixed. It equals the FIFO's request-to-data delay (parameter `FIFO_LAT`, 1 or 2), plus one more cycle when the optional output register (`OUT_REG`) is enabled. The bridge shares its clock and synchronous active-high reset with the FIFO. Each of the four byte lanes of a read has its own enable, and lanes that are not enabled read as zero.

Top module: `fifo_drain_bridge`

## Requirements
- R1: A read of word address 0 while the FIFO is not empty returns the FIFO's next word on `bus_rdata` exactly `FIFO_LAT + OUT_REG` cycles after the cycle the read is presented.
- R2: A read of address 0 while the FIFO is not empty raises `fifo_pop` in that same cycle only. Reads on consecutive cycles therefore pop one word each and return consecutive words in order.
- R3: A read of word address 1 returns 1 in bit 0 if the FIFO held data in the request cycle and 0 otherwise. Bits 31..1 are zero, and the read never raises `fifo_pop`.
- R4: A read of address 0 while `fifo_empty` is high leaves `fifo_pop` low and returns zero.
- R5: `fifo_pop` is never high in a cycle without a bus read.
- R6: Reads of word addresses 2 and 3 return zero and leave `fifo_pop` low, so the FIFO contents are untouched.
- R7: Byte lane i of `bus_rdata` (bits 8i+7..8i) is zero when `bus_be[i]` was low in the request. A data read with any byte-enable pattern, including all-zero, still pops exactly one word.
- R8: In a result slot with no read behind it, `bus_rdata` is zero.
- R9: With `OUT_REG` = 1 the result appears one cycle later than the FIFO delay alone would give, and in the cycle before that `bus_rdata` is still zero.
- R10: While `rst` is high, `fifo_pop` is low even if a data read is presented, and `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the FIFO |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe, one request per high cycle |
| bus_addr | input | ADDR_W | Word address: 0 data, 1 status |
| bus_be | input | 4 | Byte-lane enables of the read |
| bus_rdata | output | 32 | Read result after the fixed latency |
| fifo_pop | output | 1 | Read request to the FIFO |
| fifo_data | input | 32 | FIFO output word |
| fifo_empty | input | 1 | FIFO empty flag |

## Verification
A data read that takes the last word and a status read issued in the very next cycle can land in the same pipeline window. The status read has to see the empty flag that the pop has just produced, not the value from before the pop. The bench places a single word in the FIFO and issues these two reads back to back. It expects the word first and a status of zero next. Two bridges run in parallel with the same total latency but different splits, one using FIFO delay 1 with the output register and one using FIFO delay 2 without it, so that the collision is judged for both timings.

// File: rtl/fdb_pkg.sv
package fdb_pkg;
    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_POP  = 2'd1,
        KIND_STAT = 2'd2
    } kind_e;

    typedef struct packed {
        kind_e              kind;
        logic               avail;
        logic [LANES-1:0]   lanes;
    } req_t;

    localparam req_t REQ_IDLE = '{kind: KIND_NONE, avail: 1'b0, lanes: '0};

    function automatic logic [WORD_W-1:0] keep_lanes(input logic [LANES-1:0] en,
                                                     input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < LANES; i++) begin
            r[8*i +: 8] = en[i] ? w[8*i +: 8] : 8'h00;
        end
        return r;
    endfunction
endpackage

// File: rtl/fdb_decode.sv
module fdb_decode
    import fdb_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int POP_ADDR  = 0,
    parameter int STAT_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  be,
    input  logic              empty,
    output logic              pop,
    output req_t              req_q
);
    logic hit_pop;
    logic hit_stat;
    req_t req_d;

    assign hit_pop  = rd && (addr == ADDR_W'(POP_ADDR));
    assign hit_stat = rd && (addr == ADDR_W'(STAT_ADDR));
    assign pop      = hit_pop && !empty && !rst;

    always_comb begin
        req_d       = REQ_IDLE;
        req_d.lanes = be;
        req_d.avail = !empty;
        if (hit_pop && !empty) begin
            req_d.kind = KIND_POP;
        end else if (hit_stat) begin
            req_d.kind = KIND_STAT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= REQ_IDLE;
        end else begin
            req_q <= req_d;
        end
    end

    p_no_pop_in_reset_r10: assert property (@(posedge clk) rst |-> !pop);
    p_no_pop_when_empty_r4: assert property (@(posedge clk) disable iff (rst) empty |-> !pop);
    p_pop_needs_read_r5: assert property (@(posedge clk) disable iff (rst) pop |-> rd);
    p_other_addr_no_pop_r6: assert property (@(posedge clk) disable iff (rst)
        (rd && addr != ADDR_W'(POP_ADDR)) |-> !pop);
endmodule

// File: rtl/fdb_delay.sv
module fdb_delay
    import fdb_pkg::*;
#(
    parameter int DEPTH = 1
) (
    input  logic clk,
    input  logic rst,
    input  req_t in_req,
    output req_t out_req
);
    generate
        if (DEPTH == 0) begin : g_pass
            assign out_req = in_req;
        end else begin : g_pipe
            req_t stage [DEPTH];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) stage[i] <= REQ_IDLE;
                end else begin
                    stage[0] <= in_req;
                    for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
                end
            end
            assign out_req = stage[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/fdb_format.sv
module fdb_format
    import fdb_pkg::*;
#(
    parameter bit OUT_REG = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  req_t              req,
    input  logic [WORD_W-1:0] fifo_word,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] sel;

    always_comb begin
        unique case (req.kind)
            KIND_POP:  sel = keep_lanes(req.lanes, fifo_word);
            KIND_STAT: sel = keep_lanes(req.lanes, {{(WORD_W-1){1'b0}}, req.avail});
            default:   sel = '0;
        endcase
    end

    generate
        if (OUT_REG) begin : g_reg
            logic [WORD_W-1:0] hold;
            always_ff @(posedge clk) begin
                if (rst) hold <= '0;
                else     hold <= sel;
            end
            assign rdata = hold;
        end else begin : g_comb
            assign rdata = sel;
        end
    endgenerate
endmodule

// File: rtl/fifo_drain_bridge.sv
module fifo_drain_bridge
    import fdb_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int FIFO_LAT = 1,
    parameter bit OUT_REG  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    output logic [31:0]       bus_rdata,
    output logic              fifo_pop,
    input  logic [31:0]       fifo_data,
    input  logic              fifo_empty
);
    localparam int RD_LAT    = FIFO_LAT + (OUT_REG ? 1 : 0);
    localparam int EXTRA_DLY = FIFO_LAT - 1;

    req_t req_first;
    req_t req_slot;

    fdb_decode #(.ADDR_W(ADDR_W), .POP_ADDR(0), .STAT_ADDR(1)) u_decode (
        .clk   (clk),
        .rst   (rst),
        .rd    (bus_rd),
        .addr  (bus_addr),
        .be    (bus_be),
        .empty (fifo_empty),
        .pop   (fifo_pop),
        .req_q (req_first)
    );

    fdb_delay #(.DEPTH(EXTRA_DLY)) u_delay (
        .clk     (clk),
        .rst     (rst),
        .in_req  (req_first),
        .out_req (req_slot)
    );

    fdb_format #(.OUT_REG(OUT_REG)) u_format (
        .clk       (clk),
        .rst       (rst),
        .req       (req_slot),
        .fifo_word (fifo_data),
        .rdata     (bus_rdata)
    );

    logic [2:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    p_idle_slot_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (since_rst > 3'(RD_LAT) && !$past(bus_rd, RD_LAT)) |-> bus_rdata == '0);

    generate
        if (OUT_REG) begin : g_chk_reg
            p_pop_word_r1: assert property (@(posedge clk) disable iff (rst)
                (since_rst > 3'(RD_LAT) && $past(fifo_pop, RD_LAT) && $past(bus_be, RD_LAT) == 4'hF)
                |-> bus_rdata == $past(fifo_data));
        end else begin : g_chk_comb
            p_pop_word_r1: assert property (@(posedge clk) disable iff (rst)
                (since_rst > 3'(RD_LAT) && $past(fifo_pop, RD_LAT) && $past(bus_be, RD_LAT) == 4'hF)
                |-> bus_rdata == fifo_data);
        end
    endgenerate
endmodule

// File: tb/tb_fifo_drain_bridge.sv
module tb_fifo_model #(
    parameter int LAT = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push,
    input  logic [31:0] push_data,
    input  logic        pop,
    output logic [31:0] q,
    output logic        empty
);
    logic [31:0] mem [64];
    logic [5:0]  wp, rp;
    logic [6:0]  cnt;
    logic [31:0] hold;
    logic        pend;

    assign empty = (cnt == 7'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0; rp <= '0; cnt <= '0; q <= '0; hold <= '0; pend <= 1'b0;
        end else begin
            if (push) begin
                mem[wp] <= push_data;
                wp <= wp + 6'd1;
            end
            cnt <= cnt + {6'd0, push} - {6'd0, pop};
            pend <= pop;
            if (pop) begin
                rp <= rp + 6'd1;
                if (LAT == 1) q <= mem[rp];
                else          hold <= mem[rp];
            end
            if (LAT == 2 && pend) q <= hold;
        end
    end
endmodule

module tb_fifo_drain_bridge;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [3:0]  bus_be = 4'hF;
    logic        push = 1'b0;
    logic [31:0] push_data = '0;

    logic [31:0] rdata_a, rdata_b, q_a, q_b;
    logic        pop_a, pop_b, empty_a, empty_b;

    int checks = 0;
    int errors = 0;
    int pops_a = 0;
    int pops_b = 0;

    logic [31:0] expq [64];
    int head = 0;
    int tail = 0;

    always #10 clk = ~clk;

    fifo_drain_bridge #(.ADDR_W(2), .FIFO_LAT(1), .OUT_REG(1'b1)) dut (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_rdata(rdata_a), .fifo_pop(pop_a), .fifo_data(q_a), .fifo_empty(empty_a));
    tb_fifo_model #(.LAT(1)) fifo_a (
        .clk(clk), .rst(rst), .push(push), .push_data(push_data),
        .pop(pop_a), .q(q_a), .empty(empty_a));

    fifo_drain_bridge #(.ADDR_W(2), .FIFO_LAT(2), .OUT_REG(1'b0)) dut_b (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_rdata(rdata_b), .fifo_pop(pop_b), .fifo_data(q_b), .fifo_empty(empty_b));
    tb_fifo_model #(.LAT(2)) fifo_b (
        .clk(clk), .rst(rst), .push(push), .push_data(push_data),
        .pop(pop_b), .q(q_b), .empty(empty_b));

    always @(posedge clk) begin
        if (pop_a) pops_a++;
        if (pop_b) pops_b++;
    end

    function automatic logic [31:0] lanes_of(input logic [3:0] en, input logic [31:0] w);
        logic [31:0] m = '0;
        for (int i = 0; i < 4; i++) if (en[i]) m |= (32'hFF << (8 * i));
        return w & m;
    endfunction

    function automatic logic [31:0] word_n(input int n);
        return 32'h1357_9BDF + 32'(n) * 32'h0102_0408 ^ (32'(n) << 24);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic both(input string tag, input logic [31:0] exp);
        check(rdata_a == exp, {tag, " (dut)"}, rdata_a, exp);
        check(rdata_b == exp, {tag, " (dut_b)"}, rdata_b, exp);
    endtask

    task automatic put(input logic [31:0] w);
        push = 1'b1; push_data = w;
        @(negedge clk);
        push = 1'b0;
        expq[tail % 64] = w; tail++;
    endtask

    task automatic pop_expect(output logic [31:0] w);
        w = expq[head % 64]; head++;
    endtask

    // Issue one read at a negedge; return at the negedge where the result is visible.
    task automatic rd_one(input logic [1:0] a, input logic [3:0] en, input bit expect_pop, input string tag);
        bus_rd = 1'b1; bus_addr = a; bus_be = en;
        #1;
        check(pop_a == expect_pop && pop_b == expect_pop, {tag, " pop strobe"},
              {30'd0, pop_a, pop_b}, {30'd0, expect_pop, expect_pop});
        @(negedge clk);
        bus_rd = 1'b0;
        #1;
        check(pop_a == 1'b0 && pop_b == 1'b0, {tag, " pop single cycle"}, {30'd0, pop_a, pop_b}, 32'd0);
        both({tag, " R9 not early"}, 32'd0);
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] w, w2;
        int pa, pb;
        bus_rd = 1'b1; bus_addr = 2'd0; bus_be = 4'hF;
        repeat (3) @(negedge clk);
        check(pop_a == 1'b0 && pop_b == 1'b0, "R10 no pop in reset", {30'd0, pop_a, pop_b}, 32'd0);
        both("R10 rdata zero in reset", 32'd0);
        rst = 1'b0; bus_rd = 1'b0;
        repeat (3) @(negedge clk);

        rd_one(2'd1, 4'hF, 1'b0, "R3 status empty");
        both("R3 status empty", 32'd0);
        rd_one(2'd0, 4'hF, 1'b0, "R4 read when empty");
        both("R4 read when empty", 32'd0);

        for (int i = 0; i < 4; i++) put(word_n(i));
        pa = pops_a; pb = pops_b;
        repeat (3) begin
            @(negedge clk);
            both("R8 idle slot", 32'd0);
        end
        check(pops_a == pa && pops_b == pb, "R5 no pop while idle", 32'(pops_a - pa), 32'd0);

        rd_one(2'd1, 4'hF, 1'b0, "R3 status ready");
        both("R3 status ready", 32'd1);

        for (int i = 0; i < 2; i++) begin
            rd_one(2'd0, 4'hF, 1'b1, "R2 single read");
            pop_expect(w);
            both("R1 single word", w);
        end

        pa = pops_a; pb = pops_b;
        bus_rd = 1'b1; bus_addr = 2'd0; bus_be = 4'hF;
        #1;
        check(pop_a && pop_b, "R2 b2b first pop", {30'd0, pop_a, pop_b}, 32'd3);
        @(negedge clk);
        #1;
        check(pop_a && pop_b, "R2 b2b second pop", {30'd0, pop_a, pop_b}, 32'd3);
        @(negedge clk);
        bus_rd = 1'b0;
        pop_expect(w);
        both("R2 b2b first word", w);
        @(negedge clk);
        pop_expect(w);
        both("R2 b2b second word", w);
        check(pops_a - pa == 2 && pops_b - pb == 2, "R2 one pop per read", 32'(pops_a - pa), 32'd2);

        put(word_n(4));
        rd_one(2'd2, 4'hF, 1'b0, "R6 addr 2");
        both("R6 addr 2 data", 32'd0);
        rd_one(2'd3, 4'hF, 1'b0, "R6 addr 3");
        both("R6 addr 3 data", 32'd0);
        rd_one(2'd0, 4'hF, 1'b1, "R6 word kept");
        pop_expect(w);
        both("R6 word kept", w);

        put(word_n(5));
        bus_rd = 1'b1; bus_addr = 2'd0; bus_be = 4'hF;
        @(negedge clk);
        bus_addr = 2'd1;
        #1;
        check(!pop_a && !pop_b, "R3 status after last pop no pop", {30'd0, pop_a, pop_b}, 32'd0);
        @(negedge clk);
        bus_rd = 1'b0;
        pop_expect(w);
        both("R1 last word", w);
        @(negedge clk);
        both("R3 status after last pop", 32'd0);

        for (int e = 0; e < 16; e++) begin
            put(word_n(10 + e));
            rd_one(2'd0, 4'(e), 1'b1, "R7 lane pop");
            pop_expect(w);
            w2 = lanes_of(4'(e), w);
            both("R7 lane mask", w2);
        end
        rd_one(2'd1, 4'hF, 1'b0, "R7 all consumed");
        both("R7 all consumed", 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule